// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer Channel

This block is a single programmable timer channel that sits on a CPU register bus. A 16-bit up-counter advances at one of four rates. Three rates come from the bus clock: every cycle, one step per 16 cycles and one step per 256 cycles. The fourth rate is one step for each cycle in which an external line-blanking pulse input is high. Each new count is compared against a programmable target. The counter also watches for the wrap past 0xFFFF. Either event can set a sticky status flag and pulse the interrupt output.

Software programs four registers through a two-bit address, a write strobe and a 32-bit data bus. Reads are combinational, and the upper 16 bits always return zero. The target match is one-shot per counter cycle. Once the target has been met, or once a target is written at or below the current count, the match stays disarmed until the counter wraps. This keeps a stale target from firing at once or firing repeatedly. The count can optionally restart from zero on a match, but only when the match interrupt is enabled.

Register addresses: 0 holds the count, 1 the mode, 2 the target and 3 a plain hold value. Mode layout: bits [1:0] select the rate source (0 is every bus cycle, 1 is every 16 cycles, 2 is every 256 cycles, 3 is the line pulse). Bits [5:2] are stored with no effect. Bit 6 enables restart-on-match. Bit 7 enables counting. Bit 8 enables the match interrupt. Bit 9 enables the wrap interrupt. Bit 10 is the match flag and bit 11 is the wrap flag.

Top module: `timer16_channel`

## Requirements
- R1: Writes to count, target and hold keep only data bits [15:0], and every register read returns zero in bits [31:16].
- R2: Mode bits [1:0] pick the step source: 0 steps every cycle, 1 steps once per 16 cycles, 2 steps once per 256 cycles, and 3 steps once for each cycle in which `line_pulse` is high. Without a step the count does not change.
- R3: While mode bit 7 is 0 the count holds its value.
- R4: A mode write loads bits [9:0] from data [9:0]. A 1 in data bit 10 or 11 clears the match flag or the wrap flag, and a 0 leaves that flag unchanged.
- R5: When an armed step reaches count >= target with mode bit 8 set, the match flag (bit 10) is set and `irq` pulses in the same edge. With mode bit 6 also set, the count becomes count minus target and the match stays armed.
- R6: When an armed step reaches count >= target with mode bit 8 clear, no flag is set, no `irq` occurs and the count keeps running. The match is disarmed. It is also disarmed after a match with bit 8 set and bit 6 clear.
- R7: A step from 0xFFFF wraps the count to 0 and re-arms the match. With mode bit 9 set it also sets the wrap flag (bit 11) and pulses `irq`.
- R8: A count write re-arms the match, unless the new count is above the target, in which case the match stays disarmed until the next wrap.
- R9: A target write with a value at or below the current count leaves the match disarmed until the next wrap. A larger value arms it.
- R10: After reset the count is 0, the target is 0xFFFF, mode and hold are 0 and `irq` is low.
- R11: A count write does not disturb the divider phase. A mode write restarts the divider from zero.
- R12: A count or target write takes the place of any step in the same cycle. The hold register stores its value and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select (0 count, 1 mode, 2 target, 3 hold) |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| line_pulse | input | 1 | Line-blanking pulse used as step source 3 |
| irq | output | 1 | One-cycle interrupt pulse on a flagged match or wrap |

## Verification
The embedded assertions check the following on every cycle:
- the count never moves without a step or a write;
- the count holds while counting is disabled;
- a rising flag always comes with an `irq` pulse;
- a step from 0xFFFF lands on zero;
- writes of a target at or below the count, or of a count above the target, leave the match disarmed.

Some behaviour can only be shown by the bench's scenarios, run against its cycle-level model:
- the exact step spacing of each divider;
- the divider phase carried across count writes;
- write-one-to-clear on the flags;
- the suppression of interrupts when the enables are clear;
- a match that reappears only after a wrap.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

    localparam int CNT_W   = 16;
    localparam int CTRL_W  = 10;

    // control bit positions inside the mode register
    localparam int ZR_BIT  = 6;
    localparam int EN_BIT  = 7;
    localparam int TIE_BIT = 8;
    localparam int OIE_BIT = 9;
    localparam int FT_BIT  = 10;
    localparam int FO_BIT  = 11;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        SRC_BUS  = 2'd0,
        SRC_DIVA = 2'd1,
        SRC_DIVB = 2'd2,
        SRC_LINE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_MODE   = 2'd1,
        REG_TARGET = 2'd2,
        REG_HOLD   = 2'd3
    } reg_e;

    typedef struct packed {
        cnt_t              count;
        cnt_t              target;
        logic              armed;
        logic              flag_t;
        logic              flag_o;
        logic [CTRL_W-1:0] ctrl;
        logic              irq;
    } core_st_t;

endpackage

// File: rtl/timer16_prescaler.sv
module timer16_prescaler
    import timer16_pkg::*;
#(
    parameter int FAST_LOG = 4,
    parameter int SLOW_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] src,
    input  logic       restart,
    input  logic       line_pulse,
    output logic       tick
);

    localparam int PRE_W = SLOW_LOG;

    logic [PRE_W-1:0] pre_d, pre_q;
    src_e             src_sel;

    assign src_sel = src_e'(src);

    always_comb begin
        tick  = 1'b0;
        pre_d = pre_q;
        unique case (src_sel)
            SRC_BUS:  tick = run;
            SRC_DIVA: tick = run && (&pre_q[FAST_LOG-1:0]);
            SRC_DIVB: tick = run && (&pre_q);
            SRC_LINE: tick = run && line_pulse;
            default:  tick = 1'b0;
        endcase
        if (restart) begin
            pre_d = '0;
        end else if (run && (src_sel == SRC_DIVA || src_sel == SRC_DIVB)) begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/timer16_core.sv
module timer16_core
    import timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic              tgt_wr,
    input  logic              mode_wr,
    input  cnt_t              wval,
    input  logic [1:0]        w1c,
    input  logic [CTRL_W-1:0] wctrl,
    output core_st_t          st
);

    core_st_t          s_d, s_q;
    logic [CNT_W:0]    step_sum;
    cnt_t              cnt_v;
    logic              arm_v;
    logic              set_t;
    logic              set_o;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        step_sum = {1'b0, s_q.count} + 1'b1;
        cnt_v    = step_sum[CNT_W-1:0];
        arm_v    = s_q.armed;
        set_t    = 1'b0;
        set_o    = 1'b0;

        if (cnt_wr) begin
            s_d.count = wval;
            s_d.armed = !(wval > s_q.target);
        end else if (tgt_wr) begin
            s_d.target = wval;
            s_d.armed  = (wval > s_q.count);
        end else if (tick) begin
            if (step_sum[CNT_W]) begin
                arm_v = 1'b1;
                set_o = s_q.ctrl[OIE_BIT];
            end
            if (arm_v && cnt_v >= s_q.target) begin
                if (s_q.ctrl[TIE_BIT]) begin
                    set_t = 1'b1;
                    if (s_q.ctrl[ZR_BIT]) begin
                        cnt_v = cnt_v - s_q.target;
                    end else begin
                        arm_v = 1'b0;
                    end
                end else begin
                    arm_v = 1'b0;
                end
            end
            s_d.count = cnt_v;
            s_d.armed = arm_v;
        end

        if (mode_wr) begin
            s_d.ctrl   = wctrl;
            s_d.flag_t = s_q.flag_t & ~w1c[0];
            s_d.flag_o = s_q.flag_o & ~w1c[1];
        end
        s_d.flag_t = s_d.flag_t | set_t;
        s_d.flag_o = s_d.flag_o | set_o;
        s_d.irq    = set_t | set_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.target <= '1;
            s_q.armed  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign st = s_q;

    // R2: without a step or a count write the count never moves
    assert_no_step_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(s_q.count));

    // R3: disabled counter holds
    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl[EN_BIT] && !cnt_wr) |=> (s_q.count == $past(s_q.count)));

    // R5: a new match flag always comes with the interrupt pulse
    assert_tflag_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag_t) |-> s_q.irq);

    // R7: a new wrap flag always comes with the interrupt pulse
    assert_oflag_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag_o) |-> s_q.irq);

    // R7: stepping from all ones lands on zero
    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !tgt_wr && s_q.count == '1) |=> (s_q.count == '0));

    // R8: count written above target stays disarmed
    assert_cnt_wr_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && wval > s_q.target) |=> (!s_q.armed && s_q.count == $past(wval)));

    // R9: target written at or below count stays disarmed
    assert_tgt_wr_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr && !cnt_wr && wval <= s_q.count) |=> !s_q.armed);

endmodule

// File: rtl/timer16_channel.sv
module timer16_channel
    import timer16_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int FAST_LOG = 4,
    parameter int SLOW_LOG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             line_pulse,
    output logic             irq
);

    localparam int PAD_W  = BUS_W - CNT_W;
    localparam int MODE_W = FO_BIT + 1;

    reg_e     sel;
    logic     cnt_wr, tgt_wr, mode_wr, hold_wr;
    logic     tick;
    core_st_t st;
    cnt_t     hold_d, hold_q;
    cnt_t     rd_lo;
    logic     unused_wdata;

    assign sel     = reg_e'(bus_addr);
    assign cnt_wr  = bus_wr && (sel == REG_COUNT);
    assign tgt_wr  = bus_wr && (sel == REG_TARGET);
    assign mode_wr = bus_wr && (sel == REG_MODE);
    assign hold_wr = bus_wr && (sel == REG_HOLD);

    assign unused_wdata = ^bus_wdata[BUS_W-1:CNT_W];

    timer16_prescaler #(
        .FAST_LOG (FAST_LOG),
        .SLOW_LOG (SLOW_LOG)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st.ctrl[EN_BIT]),
        .src        (st.ctrl[1:0]),
        .restart    (mode_wr),
        .line_pulse (line_pulse),
        .tick       (tick)
    );

    timer16_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_wr  (cnt_wr),
        .tgt_wr  (tgt_wr),
        .mode_wr (mode_wr),
        .wval    (bus_wdata[CNT_W-1:0]),
        .w1c     (bus_wdata[FO_BIT:FT_BIT]),
        .wctrl   (bus_wdata[CTRL_W-1:0]),
        .st      (st)
    );

    always_comb begin
        hold_d = hold_q;
        if (hold_wr) begin
            hold_d = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    always_comb begin
        rd_lo = '0;
        unique case (sel)
            REG_COUNT:  rd_lo = st.count;
            REG_MODE:   rd_lo = {{(CNT_W-MODE_W){1'b0}}, st.flag_o, st.flag_t, st.ctrl};
            REG_TARGET: rd_lo = st.target;
            REG_HOLD:   rd_lo = hold_q;
            default:    rd_lo = '0;
        endcase
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_lo};
    assign irq       = st.irq;

    // R10: interrupt is quiet in the first cycle after reset release
    assert_irq_reset_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq);

endmodule

// File: tb/timer16_channel_tb.sv
module timer16_channel_tb_top;

    localparam int CLK_P = 10;
    localparam int EN  = 'h80;
    localparam int ZR  = 'h40;
    localparam int TIE = 'h100;
    localparam int OIE = 'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        line_pulse = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;

    // behavioural reference state
    int m_cnt, m_tgt, m_arm, m_ft, m_fo, m_ctrl, m_hold, m_pre, m_irq;

    always #(CLK_P/2) clk = ~clk;

    timer16_channel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .line_pulse (line_pulse),
        .irq        (irq)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_ok(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_cnt;
            1: return (m_fo << 11) | (m_ft << 10) | m_ctrl;
            2: return m_tgt;
            default: return m_hold;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tgt = 'hFFFF; m_arm = 1; m_ft = 0; m_fo = 0;
            m_ctrl = 0; m_hold = 0; m_pre = 0; m_irq = 0;
        end else begin
            int src, en, wd, a, st_t, st_o, c;
            bit tk;
            src = m_ctrl & 3;
            en  = (m_ctrl >> 7) & 1;
            tk  = (en == 1) && (src == 0 || (src == 1 && (m_pre % 16) == 15) ||
                  (src == 2 && m_pre == 255) || (src == 3 && line_pulse));
            a  = int'(bus_addr);
            wd = int'(bus_wdata) & 'hFFFF;
            st_t = 0; st_o = 0;
            if (bus_wr && a == 0) begin
                m_cnt = wd; m_arm = (wd > m_tgt) ? 0 : 1;
            end else if (bus_wr && a == 2) begin
                m_tgt = wd; m_arm = (wd > m_cnt) ? 1 : 0;
            end else if (tk) begin
                c = m_cnt + 1;
                if (c > 'hFFFF) begin
                    c = c - 'h10000; m_arm = 1;
                    if ((m_ctrl & OIE) != 0) st_o = 1;
                end
                if (m_arm == 1 && c >= m_tgt) begin
                    if ((m_ctrl & TIE) != 0) begin
                        st_t = 1;
                        if ((m_ctrl & ZR) != 0) c = c - m_tgt;
                        else m_arm = 0;
                    end else begin
                        m_arm = 0;
                    end
                end
                m_cnt = c;
            end
            if (bus_wr && a == 1) m_pre = 0;
            else if (en == 1 && (src == 1 || src == 2)) m_pre = (m_pre + 1) % 256;
            if (bus_wr && a == 1) begin
                m_ctrl = wd & 'h3FF;
                if (((wd >> 10) & 1) != 0) m_ft = 0;
                if (((wd >> 11) & 1) != 0) m_fo = 0;
            end
            if (bus_wr && a == 3) m_hold = wd;
            m_ft = m_ft | st_t;
            m_fo = m_fo | st_o;
            m_irq = st_t | st_o;
        end
        #(CLK_P/4);
        if (rst_n) begin
            if (irq) irq_seen++;
            check_eq("R5/R7 model irq", int'(irq), m_irq);
            case (int'(bus_addr))
                0: check_eq("R2 model count", int'(bus_rdata), model_read(0));
                1: check_eq("R4 model mode", int'(bus_rdata), model_read(1));
                2: check_eq("R9 model target", int'(bus_rdata), model_read(2));
                default: check_eq("R12 model hold", int'(bus_rdata), model_read(3));
            endcase
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 2'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'(a);
        #1 v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, ib;
        idle(3);
        rst_n = 1'b1;

        // R10 reset state
        rd(0, v); check_eq("R10 count after reset", v, 0);
        rd(2, v); check_eq("R10 target after reset", v, 'hFFFF);
        rd(1, v); check_eq("R10 mode after reset", v, 0);
        rd(3, v); check_eq("R10 hold after reset", v, 0);
        check_eq("R10 irq after reset", int'(irq), 0);

        // R1 truncation and zero upper half
        wr(0, 'hABCD1234);
        rd(0, v); check_eq("R1 count truncated", v, 'h1234);
        // R12 hold stores
        wr(3, 'h5555BEEF);
        rd(3, v); check_eq("R12 hold stored", v, 'hBEEF);
        // R3 disabled holds
        idle(10);
        rd(0, v); check_eq("R3 count held while off", v, 'h1234);

        // R12 write wins over a same-cycle step
        wr(2, 'h2000);
        wr(1, EN);
        wr(0, 7);
        rd(0, v); check_eq("R12 count write beats step", v, 8);

        // R5 match with restart
        wr(1, 0); wr(0, 0); wr(2, 5);
        ib = irq_seen;
        wr(1, EN | TIE | ZR);
        idle(12);
        wr(1, TIE | ZR);
        rd(1, v); check_ok("R5 match flag set", ((v >> 10) & 1) == 1, v, 'h540);
        check_ok("R4 zero in flag bit leaves it", ((v >> 10) & 1) == 1, v, 'h540);
        rd(0, v); check_ok("R5 restart keeps count below target", v < 5, v, 0);
        check_ok("R5 irq pulsed", irq_seen > ib, irq_seen, ib + 1);

        // R4 write-one-to-clear
        wr(1, 'h400);
        rd(1, v); check_eq("R4 flag cleared by one", v, 0);

        // R6 match without interrupt enable
        wr(0, 0); wr(2, 5);
        ib = irq_seen;
        wr(1, EN);
        idle(20);
        wr(1, 0);
        rd(0, v); check_ok("R6 count runs past target", v > 5, v, 6);
        rd(1, v); check_eq("R6 no match flag", v, 0);
        check_eq("R6 no irq", irq_seen, ib);

        // R7 wrap with interrupt
        wr(0, 'hFFF8); wr(2, 'h100);
        ib = irq_seen;
        wr(1, EN | OIE);
        idle(20);
        wr(1, OIE);
        rd(1, v); check_eq("R7 wrap flag set", v, 'hA00);
        rd(0, v); check_ok("R7 count wrapped", v < 'h20, v, 'h10);
        check_ok("R7 irq on wrap", irq_seen > ib, irq_seen, ib + 1);

        // R8 count above target stays disarmed until wrap
        wr(1, 'hC00);
        wr(2, 10); wr(0, 'hFFF0);
        wr(1, EN | TIE);
        idle(5);
        rd(1, v); check_eq("R8 no match before wrap", v, 'h180);
        idle(40);
        rd(1, v); check_eq("R8 match after wrap re-arm", v, 'h580);

        // R9 target at or below count disarms
        wr(1, 'hC00);
        wr(0, 100); wr(2, 200); wr(2, 50);
        wr(1, EN | TIE);
        idle(20);
        rd(1, v); check_eq("R9 no match after low target", v, 'h180);

        // R2 divide by 16
        wr(1, 'hC00); wr(0, 0);
        wr(1, EN | 1);
        idle(63);
        rd(0, v); check_eq("R2 divide-16 steps", v, 4);
        // R2 divide by 256
        wr(1, 0); wr(0, 0);
        wr(1, EN | 2);
        idle(299);
        rd(0, v); check_eq("R2 divide-256 steps", v, 1);
        // R2 line pulse source
        wr(1, 0); wr(0, 0);
        wr(1, EN | 3);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) line_pulse = 1'b1;
            @(negedge clk) line_pulse = 1'b0;
            idle(2);
        end
        rd(0, v); check_eq("R2 line pulse steps", v, 5);

        // R11 count write keeps divider phase
        wr(1, 0); wr(0, 0);
        wr(1, EN | 1);
        idle(7);
        wr(0, 100);
        idle(10);
        rd(0, v); check_eq("R11 phase kept across count write", v, 101);

        wr(1, 0);
        idle(4);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule